// File: doc/BRIEF.md
# Noise-Reduction Mode Change Sequencer

This block sits on the host side of a three-wire serial control port for an analog tape-deck signal processor. It drives four lines toward the processor: a serial clock, a data line, a strobe and an active-low reset. A local parallel request carries the target mode: noise reduction on or off, B or C characteristic, and nine further mode bits. The block turns each accepted request into one or more 14-bit mode-control frames. Each frame is shifted out while the strobe is high, and the processor latches it when the strobe falls.

A request can change noise reduction between on and off while both the current and the target characteristic are C. The block does not write such a request directly, because that would cause an audible pop. It sends four frames that pass through the B characteristic instead. Every other request is written as one frame. A busy flag covers the whole series. A one-cycle done pulse marks its end. The remote device is held in reset for a fixed time after local reset, and the serial clock comes from a parameterised divider. The divider ratio is checked at elaboration.

Top module: `nr_seq_top`

## Requirements
- R1: While `rst_n` is low, `ser_rst_n`, `ser_stb`, `ser_clk` and `done` are low and `busy` is high. After reset, `ser_rst_n` stays low for RST_TICKS serial half-periods and then goes high. `busy` falls at the same time. No strobe is raised while `ser_rst_n` is low.
- R2: Frame bit layout:
  - bits 8..0 carry `req_misc`.
  - bit 9 is 1 for noise reduction on.
  - bit 10 is 1 for the C characteristic and 0 for B.
  - bit 11 is 0.
  - bits 13..12 carry the selector code SEL_CODE, which defaults to 00 (mode control).
- R3: Each frame has exactly 14 rising edges of `ser_clk` while `ser_stb` is high. Bit 0 comes first. `ser_data` is valid at each rising edge and changes only while `ser_clk` is low. `ser_clk` is low when `ser_stb` falls, and that fall latches the frame.
- R4: `ser_clk` stays high for exactly DIV system cycles per pulse. Elaboration fails unless SYS_CLK_HZ/(2·DIV) is below 500 kHz.
- R5: A request is sent as a single frame equal to the target when any of these holds: the current characteristic is B, the target characteristic is B, or the noise-reduction state is unchanged.
- R6: From C with NR off to C with NR on, four frames are sent: C/off, B/off, B/on, C/on.
- R7: From C with NR on to C with NR off, four frames are sent: C/on, B/on, B/off, C/off.
- R8: `busy` rises in the cycle after a request is accepted. It stays high until the series ends. `done` pulses for one cycle when `busy` falls, after the last strobe fall.
- R9: A request raised while `busy` is high is ignored. It adds no frame and does not change the current mode.
- R10: Every frame of a four-frame series carries the target's nine `req_misc` bits.
- R11: The current mode is taken from the last completed request, and reset sets it to B with NR off. A request held in the cycle of the done pulse is accepted at the end of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_nr_on | input | 1 | Target noise reduction on |
| req_c_type | input | 1 | Target characteristic: 1 = C, 0 = B |
| req_misc | input | 9 | Target values of the other mode bits |
| busy | output | 1 | Series in progress or remote reset active |
| done | output | 1 | One-cycle end-of-series pulse |
| ser_clk | output | 1 | Serial clock |
| ser_data | output | 1 | Serial data, bit 0 first |
| ser_stb | output | 1 | Strobe, high during shift, falling edge latches |
| ser_rst_n | output | 1 | Remote device reset, active low |

## Verification
The end-of-series done pulse and the acceptance of the next request can fall in the same cycle. `busy` is low only in the done cycle, so a request held across it must be taken right then. The bench holds `req_valid` high through a four-frame series. It checks that `busy` is low in the done cycle and high again in the next one. It then checks that the held request's single frame follows the series. A separate pulse of `req_valid` during a series must leave the frame count and the later routing decision unchanged.

// File: rtl/nr_seq_pkg.sv
// Package: shared widths, mode record and frame construction for the
// noise-reduction mode sequencer. Assumes a 14-bit frame with the mode
// selector in the two top bits.
package nr_seq_pkg;

    localparam int FRAME_W = 14;
    localparam int MISC_W  = 9;

    typedef struct packed {
        logic [MISC_W-1:0] misc;
        logic              nr_on;
        logic              c_type;
    } mode_t;

    // Pack a mode into a frame word with the given selector code.
    function automatic logic [FRAME_W-1:0] build_frame(input mode_t m, input logic [1:0] sel);
        return {sel, 1'b0, m.c_type, m.nr_on, m.misc};
    endfunction

    // Mode to send at step idx of a series; routed series pass through B.
    function automatic mode_t step_mode(input mode_t cur, input mode_t tgt,
                                        input logic routed, input logic [1:0] idx);
        mode_t m;
        m = tgt;
        if (routed) begin
            m.nr_on  = (idx >= 2'd2) ? tgt.nr_on : cur.nr_on;
            m.c_type = (idx == 2'd0) || (idx == 2'd3);
        end
        return m;
    endfunction

endpackage

// File: rtl/nr_seq_tick.sv
// Module: half-period tick generator. Emits a one-cycle tick every DIV
// system cycles; a clear restarts the count so that the first half-period
// of a frame is full length. Assumes DIV >= 2.
module nr_seq_tick #(
    parameter int DIV = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic tick
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    assign tick = (cnt == LAST);

    // Count system cycles, wrapping at the half-period length.
    always_ff @(posedge clk) begin
        if (!rst_n || clear || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/nr_seq_shift.sv
// Module: frame shifter. On start it raises the strobe and presents bit 0,
// then toggles the serial clock once per tick for FRAME_W bits, drops the
// strobe with the clock low and reports completion one tick later.
// Assumes start only arrives while it is idle.
module nr_seq_shift
    import nr_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               start,
    input  logic [FRAME_W-1:0] frame,
    output logic               ser_clk,
    output logic               ser_data,
    output logic               ser_stb,
    output logic               frame_done
);
    localparam int LATCH_STEP = 2 * FRAME_W + 1;
    localparam int END_STEP   = 2 * FRAME_W + 2;
    localparam int TW         = $clog2(END_STEP + 1);

    logic               active;
    logic [TW-1:0]      step;
    logic [FRAME_W-1:0] sh;
    logic [TW-1:0]      nstep;

    assign nstep = step + 1'b1;

    // Walk the half-period steps of one frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active     <= 1'b0;
            step       <= '0;
            sh         <= '0;
            ser_clk    <= 1'b0;
            ser_data   <= 1'b0;
            ser_stb    <= 1'b0;
            frame_done <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            if (start && !active) begin
                active   <= 1'b1;
                step     <= '0;
                ser_stb  <= 1'b1;
                ser_clk  <= 1'b0;
                ser_data <= frame[0];
                sh       <= frame >> 1;
            end else if (active && tick) begin
                step <= nstep;
                if (nstep == TW'(LATCH_STEP)) begin
                    ser_stb  <= 1'b0;
                    ser_clk  <= 1'b0;
                    ser_data <= 1'b0;
                end else if (nstep == TW'(END_STEP)) begin
                    active     <= 1'b0;
                    frame_done <= 1'b1;
                end else if (nstep[0]) begin
                    ser_clk <= 1'b1;
                end else begin
                    ser_clk  <= 1'b0;
                    ser_data <= sh[0];
                    sh       <= sh >> 1;
                end
            end
        end
    end
endmodule

// File: rtl/nr_seq_ctrl.sv
// Module: request controller. Holds the remote device in reset for
// RST_TICKS half-periods, then accepts requests, decides between a single
// frame and a four-step route through B, issues the frames one by one and
// tracks the current mode. Assumes frame_done follows each start.
module nr_seq_ctrl
    import nr_seq_pkg::*;
#(
    parameter int         RST_TICKS = 4,
    parameter logic [1:0] SEL_CODE  = 2'b00
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               req_valid,
    input  mode_t              req_mode,
    input  logic               frame_done,
    output logic               start,
    output logic [FRAME_W-1:0] frame,
    output logic               ser_rst_n,
    output logic               busy,
    output logic               done
);
    localparam int RW = $clog2(RST_TICKS + 1);

    typedef enum logic [1:0] {S_INIT, S_IDLE, S_RUN} state_t;

    state_t        state;
    logic [RW-1:0] rst_cnt;
    mode_t         cur;
    mode_t         tgt;
    logic          routed;
    logic [1:0]    idx;
    logic          req_routed;

    assign req_routed = cur.c_type && req_mode.c_type && (cur.nr_on != req_mode.nr_on);

    // Sequence remote reset, request acceptance and frame issue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_INIT;
            rst_cnt   <= '0;
            ser_rst_n <= 1'b0;
            busy      <= 1'b1;
            done      <= 1'b0;
            start     <= 1'b0;
            frame     <= '0;
            cur       <= '0;
            tgt       <= '0;
            routed    <= 1'b0;
            idx       <= '0;
        end else begin
            done  <= 1'b0;
            start <= 1'b0;
            case (state)
                S_INIT: begin
                    if (tick) begin
                        if (rst_cnt == RW'(RST_TICKS - 1)) begin
                            ser_rst_n <= 1'b1;
                            busy      <= 1'b0;
                            state     <= S_IDLE;
                        end else begin
                            rst_cnt <= rst_cnt + 1'b1;
                        end
                    end
                end
                S_IDLE: begin
                    if (req_valid) begin
                        tgt    <= req_mode;
                        routed <= req_routed;
                        idx    <= '0;
                        busy   <= 1'b1;
                        start  <= 1'b1;
                        frame  <= build_frame(step_mode(cur, req_mode, req_routed, 2'd0), SEL_CODE);
                        state  <= S_RUN;
                    end
                end
                S_RUN: begin
                    if (frame_done) begin
                        if (!routed || idx == 2'd3) begin
                            done  <= 1'b1;
                            busy  <= 1'b0;
                            cur   <= tgt;
                            state <= S_IDLE;
                        end else begin
                            idx   <= idx + 1'b1;
                            start <= 1'b1;
                            frame <= build_frame(step_mode(cur, tgt, 1'b1, idx + 1'b1), SEL_CODE);
                        end
                    end
                end
                default: state <= S_INIT;
            endcase
        end
    end
endmodule

// File: rtl/nr_seq_top.sv
// Module: top of the noise-reduction mode sequencer. Ties the tick
// generator, shifter and controller together and rejects at elaboration a
// divider that would run the serial clock at 500 kHz or faster.
module nr_seq_top
    import nr_seq_pkg::*;
#(
    parameter int         SYS_CLK_HZ = 50_000_000,
    parameter int         DIV        = 64,
    parameter int         RST_TICKS  = 4,
    parameter logic [1:0] SEL_CODE   = 2'b00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_nr_on,
    input  logic              req_c_type,
    input  logic [MISC_W-1:0] req_misc,
    output logic              busy,
    output logic              done,
    output logic              ser_clk,
    output logic              ser_data,
    output logic              ser_stb,
    output logic              ser_rst_n
);
    localparam longint MAX_SYS_HZ = 64'(DIV) * 64'd1_000_000;

    generate
        if (64'(SYS_CLK_HZ) >= MAX_SYS_HZ) begin : g_div_too_small
            $error("serial clock divider gives 500 kHz or more");
        end
    endgenerate

    logic               tick;
    logic               start;
    logic               frame_done;
    logic [FRAME_W-1:0] frame;
    mode_t              req_mode;

    assign req_mode = '{misc: req_misc, nr_on: req_nr_on, c_type: req_c_type};

    nr_seq_tick #(.DIV(DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (start),
        .tick  (tick)
    );

    nr_seq_shift u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .start      (start),
        .frame      (frame),
        .ser_clk    (ser_clk),
        .ser_data   (ser_data),
        .ser_stb    (ser_stb),
        .frame_done (frame_done)
    );

    nr_seq_ctrl #(.RST_TICKS(RST_TICKS), .SEL_CODE(SEL_CODE)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .req_valid  (req_valid),
        .req_mode   (req_mode),
        .frame_done (frame_done),
        .start      (start),
        .frame      (frame),
        .ser_rst_n  (ser_rst_n),
        .busy       (busy),
        .done       (done)
    );
endmodule

// File: rtl/nr_seq_chk.sv
// Module: protocol checker for nr_seq_top, attached by bind. Watches only
// the top-level ports.
module nr_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic ser_clk,
    input logic ser_data,
    input logic ser_stb,
    input logic ser_rst_n
);
    // R1
    stb_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_rst_n |-> !ser_stb);

    // R3
    clk_low_at_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ser_stb) |-> !ser_clk);

    // R3
    data_moves_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_stb && $past(ser_stb) && !$stable(ser_data)) |-> !ser_clk);

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_with_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !ser_stb));

    // R8
    idle_only_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && $past(ser_rst_n)) |-> done);
endmodule

bind nr_seq_top nr_seq_chk u_nr_seq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .ser_clk   (ser_clk),
    .ser_data  (ser_data),
    .ser_stb   (ser_stb),
    .ser_rst_n (ser_rst_n)
);

// File: tb/nr_seq_top_bench.sv
module nr_seq_top_bench;
    localparam int DIV       = 64;
    localparam int RST_TICKS = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_nr_on = 1'b0;
    logic       req_c_type = 1'b0;
    logic [8:0] req_misc = '0;
    logic       busy, done, ser_clk, ser_data, ser_stb, ser_rst_n;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    nr_seq_top #(.SYS_CLK_HZ(50_000_000), .DIV(DIV), .RST_TICKS(RST_TICKS)) u_nr_seq_top (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_nr_on(req_nr_on),
        .req_c_type(req_c_type), .req_misc(req_misc), .busy(busy), .done(done),
        .ser_clk(ser_clk), .ser_data(ser_data), .ser_stb(ser_stb), .ser_rst_n(ser_rst_n)
    );

    // Vector: {expected frame count[2:0], nr_on, c_type, misc[8:0]}
    localparam int NV = 8;
    localparam logic [13:0] VEC [NV] = '{
        {3'd1, 1'b1, 1'b0, 9'h0A5},
        {3'd1, 1'b1, 1'b1, 9'h0A5},
        {3'd4, 1'b0, 1'b1, 9'h0A5},
        {3'd4, 1'b1, 1'b1, 9'h155},
        {3'd1, 1'b1, 1'b1, 9'h0F0},
        {3'd1, 1'b0, 1'b0, 9'h0F0},
        {3'd1, 1'b0, 1'b1, 9'h003},
        {3'd4, 1'b1, 1'b1, 9'h1FF}
    };

    // Frame capture from the serial pins
    logic [13:0] frames [64];
    int          fbits  [64];
    int          nfr = 0;
    logic [13:0] cap = '0;
    int          bitcnt = 0;
    logic        p_clk = 1'b0, p_stb = 1'b0;
    int          hi_cnt = 0, half_bad = 0, half_seen = 0;

    always @(negedge clk) begin
        if (ser_stb && !p_stb) begin
            bitcnt = 0;
            cap    = '0;
        end
        if (ser_stb && ser_clk && !p_clk) begin
            if (bitcnt < 14) cap[bitcnt] = ser_data;
            bitcnt++;
        end
        if (p_stb && !ser_stb && nfr < 64) begin
            frames[nfr] = cap;
            fbits[nfr]  = bitcnt;
            nfr++;
        end
        if (ser_clk) hi_cnt++;
        if (p_clk && !ser_clk) begin
            half_seen++;
            if (hi_cnt != DIV) half_bad++;
            hi_cnt = 0;
        end
        p_clk = ser_clk;
        p_stb = ser_stb;
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [13:0] mk(input logic [8:0] misc, input logic nr, input logic c);
        return {2'b00, 1'b0, c, nr, misc};
    endfunction

    // Bench model of the current mode (R11)
    logic m_nr = 1'b0, m_c = 1'b0;

    task automatic wait_done(output int cyc);
        cyc = 0;
        while (!done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic issue(input logic nr, input logic c, input logic [8:0] misc);
        while (busy) @(negedge clk);
        req_valid = 1'b1; req_nr_on = nr; req_c_type = c; req_misc = misc;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, "R8 busy after accept", busy, 1);
    endtask

    task automatic expect_series(input int base, input logic nr, input logic c, input logic [8:0] misc,
                                 input int n_tab);
        logic routed;
        int   n_exp;
        logic [13:0] e [4];
        string tag;
        routed = m_c && c && (m_nr != nr);
        n_exp  = routed ? 4 : 1;
        tag    = routed ? (nr ? "R6" : "R7") : "R5";
        if (routed) begin
            e[0] = mk(misc, m_nr, 1'b1);
            e[1] = mk(misc, m_nr, 1'b0);
            e[2] = mk(misc, nr, 1'b0);
            e[3] = mk(misc, nr, 1'b1);
        end else begin
            e[0] = mk(misc, nr, c);
        end
        if (n_tab > 0) chk(n_tab == n_exp, "R5 table count", n_tab, n_exp);
        chk(nfr - base == n_exp, tag, nfr - base, n_exp);
        for (int i = 0; i < n_exp && base + i < 64; i++) begin
            chk(frames[base+i] == e[i], routed ? "R10 R2 frame" : "R2 frame", frames[base+i], e[i]);
            chk(fbits[base+i] == 14, "R3 bit count", fbits[base+i], 14);
        end
        m_nr = nr;
        m_c  = c;
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int base, cyc, n0;
        // R1 reset state
        repeat (3) @(negedge clk);
        chk(!ser_rst_n && !ser_stb && !ser_clk && !done && busy, "R1 reset state",
            {ser_rst_n, ser_stb, ser_clk, done, busy}, 5'b00001);
        @(negedge clk);
        rst_n = 1'b1;
        cyc = 0;
        while (!ser_rst_n && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
        chk(ser_rst_n && !busy, "R1 remote reset release", {ser_rst_n, busy}, 2'b10);
        chk(cyc >= (RST_TICKS - 1) * DIV && cyc <= RST_TICKS * DIV + 2, "R1 release time", cyc, RST_TICKS * DIV);
        chk(nfr == 0, "R1 no frame in reset", nfr, 0);

        // Table of requests
        for (int v = 0; v < NV; v++) begin
            base = nfr;
            issue(VEC[v][10], VEC[v][9], VEC[v][8:0]);
            wait_done(cyc);
            chk(done && !busy, "R8 done with idle", {done, busy}, 2'b10);
            @(negedge clk);
            chk(!done, "R8 done one cycle", done, 0);
            expect_series(base, VEC[v][10], VEC[v][9], VEC[v][8:0], int'(VEC[v][13:11]));
        end

        // R9: request pulsed while busy is ignored
        base = nfr;
        issue(1'b0, 1'b1, 9'h000);
        repeat (100) @(negedge clk);
        req_valid = 1'b1; req_nr_on = 1'b1; req_c_type = 1'b0; req_misc = 9'h111;
        @(negedge clk);
        req_valid = 1'b0;
        wait_done(cyc);
        @(negedge clk);
        expect_series(base, 1'b0, 1'b1, 9'h000, 0);
        n0 = nfr;
        repeat (400) @(negedge clk);
        chk(nfr == n0 && !busy, "R9 refused request sent nothing", nfr - n0, 0);
        // The refused request must not have moved the current mode: C/off -> C/on still routes
        base = nfr;
        issue(1'b1, 1'b1, 9'h0AA);
        // R11: hold a pending request across the done cycle
        req_valid = 1'b1; req_nr_on = 1'b1; req_c_type = 1'b1; req_misc = 9'h055;
        wait_done(cyc);
        chk(!busy, "R11 busy low in done cycle", busy, 0);
        @(negedge clk);
        chk(busy, "R11 held request accepted after done", busy, 1);
        req_valid = 1'b0;
        expect_series(base, 1'b1, 1'b1, 9'h0AA, 0);
        base = nfr;
        wait_done(cyc);
        @(negedge clk);
        expect_series(base, 1'b1, 1'b1, 9'h055, 0);

        // R11: reset mid-series returns to B/off
        issue(1'b0, 1'b1, 9'h0C3);
        repeat (300) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!ser_rst_n && !ser_stb && busy && !ser_clk, "R1 reset during series",
            {ser_rst_n, ser_stb, busy, ser_clk}, 4'b0010);
        rst_n = 1'b1;
        m_nr = 1'b0; m_c = 1'b0;
        while (busy) @(negedge clk);
        base = nfr;
        issue(1'b1, 1'b1, 9'h01E);
        wait_done(cyc);
        @(negedge clk);
        expect_series(base, 1'b1, 1'b1, 9'h01E, 0);

        // R4 half-period
        chk(half_seen > 0 && half_bad == 0, "R4 clock high time", half_bad, 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule